// File: doc/BRIEF.md
# Channel Transfer Sequencer

This block is the control engine of a multi-channel memory-to-memory copy unit. It serves one channel at a time. An arbiter outside the block picks the channel and offers it on `grant_vld`/`grant_ch`. The sequencer reads that channel's three-word descriptor from a table in system memory. It then moves a batch of data words, one read beat and one write beat per word. Last, it writes the updated control word back to the table. Every memory access uses a simple master port with a valid/ready handshake and a 3-bit protection attribute.

**Descriptor table**

- Each channel owns 16 bytes at `tbl_base + ch*16`.
  - Offset +0 holds the source end pointer.
  - Offset +4 holds the destination end pointer.
  - Offset +8 holds the control word.
- A second, alternate table follows the primary table at `tbl_base + NCH*16`.
- The block reads the alternate table when the channel's `alt_sel` bit is set.

**State code**

The state code is four bits. Software can read it, so the encoding is fixed:

| Code | State | Meaning |
|------|-------|---------|
| 0x0 | IDLE | no channel in service |
| 0x1 | GET_CTRL | read the control word |
| 0x2 | GET_SEND | read the source end pointer |
| 0x3 | GET_DEND | read the destination end pointer |
| 0x4 | RD_DATA | read one source word |
| 0x5 | WR_DATA | write one destination word |
| 0x6 | HOLD_REQ | wait until the request is released |
| 0x7 | PUT_CTRL | write the control word back |
| 0x8 | STALL | stopped after a bus error |
| 0x9 | DONE | one-cycle completion |
| 0xA | SG_SWAP | switch to the other descriptor table |

**Transitions**

- IDLE→GET_CTRL: on a grant while `run_en` is high.
- GET_CTRL→GET_SEND→GET_DEND: each step on a completed access.
- GET_DEND→RD_DATA: when the count is non-zero.
- GET_DEND→PUT_CTRL: when the count is zero.
- RD_DATA→WR_DATA: on a completed read.
- WR_DATA→RD_DATA: while the batch continues.
- WR_DATA→HOLD_REQ: at the end of the batch, when the channel waits for release.
- WR_DATA→PUT_CTRL: at the end of the batch, when the channel does not wait.
- HOLD_REQ→PUT_CTRL: when the request drops.
- PUT_CTRL→IDLE: when words remain.
- PUT_CTRL→DONE: when the count is exhausted and scatter-gather is off.
- PUT_CTRL→SG_SWAP: when the count is exhausted and scatter-gather is on.
- DONE→IDLE and SG_SWAP→GET_CTRL: unconditional.
- Any access state→STALL: on a bus error.
- STALL→IDLE: on a rising edge of `run_en`.

Top module: `xfer_sequencer`

## Requirements
- R1: `state_code` takes only the values 0x0 to 0xA listed above and never enters 0xB to 0xF.
- R2: After a grant, the block reads three descriptor words in this order: +8 (control), +0 (source end), +4 (destination end). The descriptor sits at `tbl_base + ch*16`, or at `tbl_base + NCH*16 + ch*16` when `alt_sel[ch]` is 1.
- R3: The control word has these fields:
  - bits [3:0]: rate R.
  - bits [13:4]: remaining word count N.
  - bits [16:14]: source protection.
  - bits [19:17]: destination protection.
  - bit [20]: scatter-gather enable.

  Each data word is read at `src_end - (N-1)*4` and then written at `dst_end - (N-1)*4`. N drops by one after each write. One service moves min(2^R, N) words.
- R4: The write-back stores the control word at +8 with the updated count. All other bits are unchanged.
- R5: When the count is exhausted and scatter-gather is off, the write-back leads to state 0x9 for exactly one cycle. During that cycle `done_pulse` is one-hot on the serviced channel. If words remain, the write-back leads to 0x0 and no done pulse is given.
- R6: If `wait_req_en[ch]` is 1, the block sits in 0x6 after the data phase with no bus access while `req_level[ch]` is high. It goes on to 0x7 once the request drops.
- R7: The descriptor reads and the write-back carry `prot_glb` on `m_prot`. The data read carries the source protection field and the data write carries the destination protection field.
- R8: While `run_en` is low, the block stays in 0x0 and ignores grants.
- R9: An access that completes with `m_err` moves the block to 0x8 and sets `err_flag`. The flag stays set until `err_clr`. The block leaves 0x8 for 0x0 only on a rising edge of `run_en`.
- R10: While `m_vld` is high and `m_rdy` is low, `m_vld`, `m_addr`, `m_wr` and `m_wdata` hold steady.
- R11: When the count is exhausted and scatter-gather is on, the write-back leads to 0xA for one cycle. The block then fetches the same channel's descriptor again from the other table, starting at state 0x1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| run_en | input | 1 | global enable |
| err_clr | input | 1 | clears the sticky error flag |
| prot_glb | input | 3 | protection bits for descriptor accesses: {cacheable, bufferable, privileged} |
| tbl_base | input | AW | base address of the primary descriptor table |
| alt_sel | input | NCH | per-channel alternate-table select |
| wait_req_en | input | NCH | per-channel wait-for-release enable |
| req_level | input | NCH | per-channel request levels |
| grant_vld | input | 1 | arbiter offers a channel |
| grant_ch | input | CH_W | offered channel number |
| m_vld | output | 1 | memory access valid |
| m_wr | output | 1 | 1 = write, 0 = read |
| m_addr | output | AW | byte address |
| m_wdata | output | DW | write data |
| m_prot | output | 3 | protection attribute |
| m_rdy | input | 1 | access completes this cycle |
| m_rdata | input | DW | read data |
| m_err | input | 1 | completing access failed |
| state_code | output | 4 | encoded sequencer state |
| err_flag | output | 1 | sticky bus-error flag |
| done_pulse | output | NCH | one-cycle per-channel completion |

## Verification
The checker watches these rules on every cycle:

- The state code stays within its legal range.
- A pending access stays stable until `m_rdy`.
- An error always leads to 0x8.
- The error flag is sticky.
- Idle gating holds while `run_en` is low.
- The hold in 0x6 lasts while the request is up.
- 0x9 and 0xA each last one cycle, and the done pulse is one-hot.

Only the directed scenarios can show the data movement itself. They check the descriptor fetch order and the alternate-table address. They check the end-relative item addressing and the batch limit set by 2^R. They check that a later grant resumes from the written-back count, the per-access protection source, and the scatter-gather refetch.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE     = 4'h0,
        ST_GET_CTRL = 4'h1,
        ST_GET_SEND = 4'h2,
        ST_GET_DEND = 4'h3,
        ST_RD_DATA  = 4'h4,
        ST_WR_DATA  = 4'h5,
        ST_HOLD_REQ = 4'h6,
        ST_PUT_CTRL = 4'h7,
        ST_STALL    = 4'h8,
        ST_DONE     = 4'h9,
        ST_SG_SWAP  = 4'hA
    } seq_state_e;

    localparam int DESC_SH = 4;   // 16 bytes per descriptor
    localparam int WORD_SH = 2;   // 4-byte data items
endpackage

// File: rtl/xseq_addr_gen.sv
module xseq_addr_gen
    import xseq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int NCH   = 8,
    parameter int CH_W  = 3,
    parameter int CNT_W = 10
) (
    input  seq_state_e       state,
    input  logic [AW-1:0]    tbl_base,
    input  logic [CH_W-1:0]  ch,
    input  logic             alt,
    input  logic [AW-1:0]    src_end,
    input  logic [AW-1:0]    dst_end,
    input  logic [CNT_W-1:0] cnt,
    input  logic [2:0]       prot_glb,
    input  logic [2:0]       prot_src,
    input  logic [2:0]       prot_dst,
    output logic             acc,
    output logic [AW-1:0]    addr,
    output logic [2:0]       prot
);
    localparam logic [AW-1:0] ALT_OFS = AW'(NCH) << DESC_SH;

    logic [AW-1:0] desc_base;
    logic [AW-1:0] item_back;

    assign desc_base = tbl_base + (alt ? ALT_OFS : '0) + (AW'(ch) << DESC_SH);
    assign item_back = AW'(cnt - CNT_W'(1)) << WORD_SH;

    always_comb begin
        acc  = 1'b1;
        addr = desc_base;
        prot = prot_glb;
        unique case (state)
            ST_GET_CTRL: addr = desc_base + AW'(8);
            ST_GET_SEND: addr = desc_base;
            ST_GET_DEND: addr = desc_base + AW'(4);
            ST_PUT_CTRL: addr = desc_base + AW'(8);
            ST_RD_DATA: begin
                addr = src_end - item_back;
                prot = prot_src;
            end
            ST_WR_DATA: begin
                addr = dst_end - item_back;
                prot = prot_dst;
            end
            default: acc = 1'b0;
        endcase
    end
endmodule

// File: rtl/xseq_done_dec.sv
module xseq_done_dec #(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic            fire,
    input  logic [CH_W-1:0] ch,
    output logic [NCH-1:0]  pulse
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign pulse[i] = fire && (ch == CH_W'(i));
    end
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
    import xseq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CNT_W  = 10,
    parameter int RATE_W = 4,
    parameter int CH_W   = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            err_clr,
    input  logic [2:0]      prot_glb,
    input  logic [AW-1:0]   tbl_base,
    input  logic [NCH-1:0]  alt_sel,
    input  logic [NCH-1:0]  wait_req_en,
    input  logic [NCH-1:0]  req_level,
    input  logic            grant_vld,
    input  logic [CH_W-1:0] grant_ch,
    output logic            m_vld,
    output logic            m_wr,
    output logic [AW-1:0]   m_addr,
    output logic [DW-1:0]   m_wdata,
    output logic [2:0]      m_prot,
    input  logic            m_rdy,
    input  logic [DW-1:0]   m_rdata,
    input  logic            m_err,
    output logic [3:0]      state_code,
    output logic            err_flag,
    output logic [NCH-1:0]  done_pulse
);
    localparam int RATE_LSB  = 0;
    localparam int CNT_LSB   = RATE_LSB + RATE_W;
    localparam int SPROT_LSB = CNT_LSB + CNT_W;
    localparam int DPROT_LSB = SPROT_LSB + 3;
    localparam int SG_BIT    = DPROT_LSB + 3;
    localparam int BEAT_W    = 1 << RATE_W;

    seq_state_e       state_q, state_d;
    logic [CH_W-1:0]  cur_ch;
    logic             cur_alt;
    logic [DW-1:0]    ctrl_q;
    logic [AW-1:0]    src_end, dst_end;
    logic [DW-1:0]    data_q;
    logic [BEAT_W-1:0] beat_q;
    logic             run_q;

    logic [CNT_W-1:0]  cnt;
    logic [RATE_W-1:0] rate;
    logic [BEAT_W-1:0] beat_last;
    logic              period_end, acc_ok, acc_bad, acc;

    assign cnt        = ctrl_q[CNT_LSB +: CNT_W];
    assign rate       = ctrl_q[RATE_LSB +: RATE_W];
    assign beat_last  = (BEAT_W'(1) << rate) - BEAT_W'(1);
    assign period_end = (cnt == CNT_W'(1)) || (beat_q == beat_last);
    assign acc_ok     = m_vld && m_rdy && !m_err;
    assign acc_bad    = m_vld && m_rdy && m_err;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (run_en && grant_vld) state_d = ST_GET_CTRL;
            ST_GET_CTRL: if (acc_ok) state_d = ST_GET_SEND;
            ST_GET_SEND: if (acc_ok) state_d = ST_GET_DEND;
            ST_GET_DEND: if (acc_ok) state_d = (cnt == '0) ? ST_PUT_CTRL : ST_RD_DATA;
            ST_RD_DATA:  if (acc_ok) state_d = ST_WR_DATA;
            ST_WR_DATA:
                if (acc_ok) begin
                    if (!period_end)              state_d = ST_RD_DATA;
                    else if (wait_req_en[cur_ch]) state_d = ST_HOLD_REQ;
                    else                          state_d = ST_PUT_CTRL;
                end
            ST_HOLD_REQ: if (!req_level[cur_ch]) state_d = ST_PUT_CTRL;
            ST_PUT_CTRL:
                if (acc_ok) begin
                    if (cnt != '0)         state_d = ST_IDLE;
                    else if (ctrl_q[SG_BIT]) state_d = ST_SG_SWAP;
                    else                   state_d = ST_DONE;
                end
            ST_DONE:     state_d = ST_IDLE;
            ST_SG_SWAP:  state_d = ST_GET_CTRL;
            ST_STALL:    if (run_en && !run_q) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (acc_bad) state_d = ST_STALL;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // channel context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch   <= '0;
            cur_alt  <= 1'b0;
            ctrl_q   <= '0;
            src_end  <= '0;
            dst_end  <= '0;
            data_q   <= '0;
            beat_q   <= '0;
            run_q    <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            run_q <= run_en;
            if (acc_bad)      err_flag <= 1'b1;
            else if (err_clr) err_flag <= 1'b0;
            unique case (state_q)
                ST_IDLE:
                    if (run_en && grant_vld) begin
                        cur_ch  <= grant_ch;
                        cur_alt <= alt_sel[grant_ch];
                        beat_q  <= '0;
                    end
                ST_GET_CTRL: if (acc_ok) ctrl_q  <= m_rdata;
                ST_GET_SEND: if (acc_ok) src_end <= AW'(m_rdata);
                ST_GET_DEND: if (acc_ok) dst_end <= AW'(m_rdata);
                ST_RD_DATA:  if (acc_ok) data_q  <= m_rdata;
                ST_WR_DATA:
                    if (acc_ok) begin
                        ctrl_q[CNT_LSB +: CNT_W] <= cnt - CNT_W'(1);
                        beat_q <= beat_q + BEAT_W'(1);
                    end
                ST_SG_SWAP: begin
                    cur_alt <= ~cur_alt;
                    beat_q  <= '0;
                end
                default: ;
            endcase
        end
    end

    xseq_addr_gen #(.AW(AW), .NCH(NCH), .CH_W(CH_W), .CNT_W(CNT_W)) u_addr (
        .state    (state_q),
        .tbl_base (tbl_base),
        .ch       (cur_ch),
        .alt      (cur_alt),
        .src_end  (src_end),
        .dst_end  (dst_end),
        .cnt      (cnt),
        .prot_glb (prot_glb),
        .prot_src (ctrl_q[SPROT_LSB +: 3]),
        .prot_dst (ctrl_q[DPROT_LSB +: 3]),
        .acc      (acc),
        .addr     (m_addr),
        .prot     (m_prot)
    );

    xseq_done_dec #(.NCH(NCH), .CH_W(CH_W)) u_done (
        .fire  (state_q == ST_DONE),
        .ch    (cur_ch),
        .pulse (done_pulse)
    );

    // outputs
    always_comb begin
        m_vld      = acc;
        m_wr       = (state_q == ST_WR_DATA) || (state_q == ST_PUT_CTRL);
        m_wdata    = (state_q == ST_WR_DATA) ? data_q : ctrl_q;
        state_code = state_q;
    end
endmodule

// File: rtl/xseq_chk.sv
module xseq_chk #(
    parameter int NCH  = 8,
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_en,
    input logic            err_clr,
    input logic [NCH-1:0]  req_level,
    input logic [CH_W-1:0] cur_ch,
    input logic            m_vld,
    input logic            m_wr,
    input logic [AW-1:0]   m_addr,
    input logic [DW-1:0]   m_wdata,
    input logic            m_rdy,
    input logic            m_err,
    input logic [3:0]      state_code,
    input logic            err_flag,
    input logic [NCH-1:0]  done_pulse
);
    a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 4'hA);

    a_r10_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        m_vld && !m_rdy |=> m_vld && $stable(m_addr) && $stable(m_wr) && $stable(m_wdata));

    a_r9_err_stall: assert property (@(posedge clk) disable iff (!rst_n)
        m_vld && m_rdy && m_err |=> state_code == 4'h8 && err_flag);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !err_clr |=> err_flag);

    a_r8_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 4'h0 && !run_en |=> state_code == 4'h0);

    a_r6_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 4'h6 && req_level[cur_ch] |=> state_code == 4'h6);

    a_r6_no_bus_wait: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 4'h6 |-> !m_vld);

    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 4'h9 |=> state_code == 4'h0);

    a_r5_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse != '0 |-> state_code == 4'h9 && $onehot0(done_pulse));

    a_r11_sg_refetch: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 4'hA |=> state_code == 4'h1);
endmodule

bind xfer_sequencer xseq_chk #(.NCH(NCH), .AW(AW), .DW(DW), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .err_clr    (err_clr),
    .req_level  (req_level),
    .cur_ch     (cur_ch),
    .m_vld      (m_vld),
    .m_wr       (m_wr),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata),
    .m_rdy      (m_rdy),
    .m_err      (m_err),
    .state_code (state_code),
    .err_flag   (err_flag),
    .done_pulse (done_pulse)
);

// File: tb/xfer_sequencer_test.sv
`timescale 1ns/1ps
module xfer_sequencer_test;
    localparam int NCH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0, err_clr = 1'b0;
    logic [2:0] prot_glb = 3'b110;
    logic [31:0] tbl_base = 32'h0;
    logic [NCH-1:0] alt_sel = '0, wait_req_en = '0, req_level = '0;
    logic grant_vld = 1'b0;
    logic [2:0] grant_ch = '0;
    logic m_vld, m_wr, m_rdy = 1'b0, m_err = 1'b0;
    logic [31:0] m_addr, m_wdata, m_rdata = '0;
    logic [2:0] m_prot;
    logic [3:0] state_code;
    logic err_flag;
    logic [NCH-1:0] done_pulse;

    always #2 clk = ~clk;

    xfer_sequencer uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .err_clr(err_clr),
        .prot_glb(prot_glb), .tbl_base(tbl_base), .alt_sel(alt_sel),
        .wait_req_en(wait_req_en), .req_level(req_level),
        .grant_vld(grant_vld), .grant_ch(grant_ch),
        .m_vld(m_vld), .m_wr(m_wr), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_prot(m_prot), .m_rdy(m_rdy), .m_rdata(m_rdata), .m_err(m_err),
        .state_code(state_code), .err_flag(err_flag), .done_pulse(done_pulse)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    // memory model and logs
    logic [31:0] mem [0:255];
    logic [31:0] tr_addr [0:63];
    logic [31:0] tr_data [0:63];
    logic        tr_wr   [0:63];
    logic [2:0]  tr_prot [0:63];
    int tr_n = 0, done_n = 0, st9_n = 0, lat_n = 0, mem_lat = 0;
    logic [15:0] st_seen = '0;
    logic [NCH-1:0] done_or = '0;
    logic err_arm = 1'b0;
    logic [31:0] err_addr = '0;

    always @(negedge clk) begin
        st_seen = st_seen | (16'h1 << state_code);
        if (state_code == 4'h9) st9_n++;
        if (done_pulse != '0) begin done_n++; done_or = done_or | done_pulse; end
        if (m_vld) begin
            if (lat_n < mem_lat) begin
                m_rdy = 1'b0; m_err = 1'b0; lat_n++;
            end else begin
                lat_n = 0;
                m_rdy = 1'b1;
                m_err = err_arm && (m_addr == err_addr);
                m_rdata = mem[m_addr[9:2]];
                if (m_wr && !m_err) mem[m_addr[9:2]] = m_wdata;
                if (tr_n < 64) begin
                    tr_addr[tr_n] = m_addr; tr_data[tr_n] = m_wdata;
                    tr_wr[tr_n] = m_wr; tr_prot[tr_n] = m_prot;
                    tr_n++;
                end
            end
        end else begin
            m_rdy = 1'b0; m_err = 1'b0; lat_n = 0;
        end
    end

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            summary();
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int rate, input int cnt, input logic [2:0] sp,
                                       input logic [2:0] dp, input logic sg);
        return {11'b0, sg, dp, sp, cnt[9:0], rate[3:0]};
    endfunction

    task automatic set_desc(input int base, input logic [31:0] se,
                            input logic [31:0] de, input logic [31:0] ctl);
        mem[base >> 2] = se; mem[(base >> 2) + 1] = de; mem[(base >> 2) + 2] = ctl;
    endtask

    task automatic clear_logs();
        tr_n = 0; done_n = 0; st9_n = 0; st_seen = '0; done_or = '0;
    endtask

    task automatic wait_state(input logic [3:0] a, input logic [3:0] b);
        int g = 0;
        while (state_code != a && state_code != b && g < 3000) begin
            @(negedge clk); g++;
        end
    endtask

    task automatic run_chan(input int ch);
        @(negedge clk);
        clear_logs();
        grant_ch = 3'(ch); grant_vld = 1'b1;
        @(negedge clk);
        grant_vld = 1'b0;
        wait_state(4'h0, 4'h8);
    endtask

    task automatic t_reset();
        chk("R1", "reset state", 32'(state_code), 32'h0);
        chk("R10", "reset m_vld", 32'(m_vld), 32'h0);
        chk("R9", "reset err_flag", 32'(err_flag), 32'h0);
        chk("R5", "reset done_pulse", 32'(done_pulse), 32'h0);
    endtask

    task automatic t_idle_gate();
        run_en = 1'b0;
        @(negedge clk);
        clear_logs();
        grant_ch = 3'd2; grant_vld = 1'b1;
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk("R8", "state with run_en low", 32'(state_code), 32'h0);
        chk("R8", "no bus access with run_en low", 32'(tr_n), 32'h0);
        grant_vld = 1'b0;
        run_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        for (int i = 0; i < 3; i++) mem[(32'h100 >> 2) + i] = 32'hA000_0000 + i;
        set_desc(32'h20, 32'h108, 32'h188, mk(2, 3, 3'b101, 3'b010, 1'b0));
        run_chan(2);
        chk("R2", "access count", 32'(tr_n), 32'd10);
        chk("R2", "1st fetch addr (ctrl)", tr_addr[0], 32'h28);
        chk("R2", "2nd fetch addr (src end)", tr_addr[1], 32'h20);
        chk("R2", "3rd fetch addr (dst end)", tr_addr[2], 32'h24);
        chk("R7", "ctrl fetch prot", 32'(tr_prot[0]), 32'b110);
        chk("R3", "first source addr", tr_addr[3], 32'h100);
        chk("R7", "source read prot", 32'(tr_prot[3]), 32'b101);
        chk("R3", "first dest addr", tr_addr[4], 32'h180);
        chk("R7", "dest write prot", 32'(tr_prot[4]), 32'b010);
        chk("R3", "last dest addr", tr_addr[8], 32'h188);
        chk("R3", "dest word 0", mem[32'h180 >> 2], 32'hA000_0000);
        chk("R3", "dest word 2", mem[32'h188 >> 2], 32'hA000_0002);
        chk("R4", "write-back addr", tr_addr[9], 32'h28);
        chk("R4", "write-back data", tr_data[9], mk(2, 0, 3'b101, 3'b010, 1'b0));
        chk("R7", "write-back prot", 32'(tr_prot[9]), 32'b110);
        chk("R5", "done cycles", 32'(done_n), 32'd1);
        chk("R5", "done channel", 32'(done_or), 32'h04);
        chk("R5", "state 9 cycles", 32'(st9_n), 32'd1);
    endtask

    task automatic t_rate();
        mem_lat = 2;
        for (int i = 0; i < 6; i++) mem[(32'h1C0 >> 2) + i] = 32'hB0 + i;
        set_desc(32'h50, 32'h1D4, 32'h1F4, mk(1, 6, 3'b000, 3'b000, 1'b0));
        run_chan(5);
        chk("R3", "batch access count", 32'(tr_n), 32'd8);
        chk("R3", "batch first source", tr_addr[3], 32'h1C0);
        chk("R3", "batch second dest", tr_addr[6], 32'h1E4);
        chk("R3", "dest word moved", mem[32'h1E4 >> 2], 32'hB1);
        chk("R4", "partial write-back", tr_data[7], mk(1, 4, 3'b000, 3'b000, 1'b0));
        chk("R5", "no done on partial", 32'(done_n), 32'd0);
        chk("R5", "back to idle", 32'(state_code), 32'h0);
        run_chan(5);
        chk("R3", "resume source addr", tr_addr[3], 32'h1C8);
        chk("R4", "second write-back", tr_data[7], mk(1, 2, 3'b000, 3'b000, 1'b0));
        mem_lat = 0;
    endtask

    task automatic t_wait();
        mem[32'h120 >> 2] = 32'hC0DE;
        set_desc(32'h10, 32'h120, 32'h140, mk(0, 1, 3'b000, 3'b000, 1'b0));
        wait_req_en = 8'h02; req_level = 8'h02;
        @(negedge clk);
        clear_logs();
        grant_ch = 3'd1; grant_vld = 1'b1;
        @(negedge clk);
        grant_vld = 1'b0;
        wait_state(4'h6, 4'h8);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R6", "held in wait", 32'(state_code), 32'h6);
            chk("R6", "no access in wait", 32'(m_vld), 32'h0);
        end
        req_level = '0;
        wait_state(4'h0, 4'h8);
        chk("R6", "write-back after release", tr_addr[tr_n - 1], 32'h18);
        chk("R6", "done after release", 32'(done_or), 32'h02);
        chk("R3", "data moved in wait mode", mem[32'h140 >> 2], 32'hC0DE);
        wait_req_en = '0;
    endtask

    task automatic t_alt();
        alt_sel = 8'h08;
        set_desc(32'hB0, 32'h130, 32'h150, mk(0, 1, 3'b000, 3'b000, 1'b0));
        run_chan(3);
        chk("R2", "alternate ctrl addr", tr_addr[0], 32'hB8);
        chk("R2", "alternate src end addr", tr_addr[1], 32'hB0);
        chk("R4", "alternate write-back addr", tr_addr[5], 32'hB8);
        chk("R5", "alternate done channel", 32'(done_or), 32'h08);
        alt_sel = '0;
    endtask

    task automatic t_sg();
        mem[32'h164 >> 2] = 32'h5A5A;
        set_desc(32'h40, 32'h160, 32'h170, mk(0, 1, 3'b000, 3'b000, 1'b1));
        set_desc(32'hC0, 32'h164, 32'h174, mk(0, 1, 3'b000, 3'b000, 1'b0));
        run_chan(4);
        chk("R11", "primary write-back", tr_addr[5], 32'h48);
        chk("R11", "swap state visited", 32'(st_seen[10]), 32'h1);
        chk("R11", "refetch from alternate", tr_addr[6], 32'hC8);
        chk("R11", "alternate data moved", mem[32'h174 >> 2], 32'h5A5A);
        chk("R5", "single done after chain", 32'(done_n), 32'd1);
    endtask

    task automatic t_err();
        set_desc(32'h60, 32'h180, 32'h1A0, mk(0, 2, 3'b000, 3'b000, 1'b0));
        err_addr = 32'h17C; err_arm = 1'b1;
        run_chan(6);
        chk("R9", "stall on error", 32'(state_code), 32'h8);
        chk("R9", "error flag set", 32'(err_flag), 32'h1);
        chk("R9", "failing access addr", tr_addr[3], 32'h17C);
        err_arm = 1'b0;
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R9", "stays stalled", 32'(state_code), 32'h8);
        run_en = 1'b0;
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        chk("R9", "leaves stall on rising enable", 32'(state_code), 32'h0);
        chk("R9", "flag still sticky", 32'(err_flag), 32'h1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk("R9", "flag cleared", 32'(err_flag), 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_idle_gate();
        t_basic();
        t_rate();
        t_wait();
        t_alt();
        t_sg();
        t_err();
        chk("R1", "final state legal", 32'(st_seen[15:11]), 32'h0);
        summary();
    end
endmodule